// File: doc/BRIEF.md
# UART FIFO Threshold and Request Logic

This block turns the occupancy of a UART's 64-entry receive and transmit FIFOs into service requests. It produces three things from the fill counts and three configuration bytes: interrupt lines for "receive data ready", "receive idle timeout" and "transmit room available", and separate DMA request lines for each direction. The FIFO storage, the shift registers and the register bus are outside it. The fill levels, a strobe for each byte written into the receive FIFO, a strobe for each byte read out of it, and a one-cycle pulse per serial bit time all arrive as inputs.

Each direction has a 6-bit trigger. In fine mode the trigger is assembled from a 2-bit field in the FIFO control byte and a 4-bit field in the trigger-level byte. In coarse mode it is either the 4-bit field times four or a fixed table entry. The DMA thresholds use the same triggers as the interrupts. A transmit-empty option makes the transmit interrupt wait for a fully drained FIFO whatever the trigger is. Software sets a pulse per direction to clear that FIFO. The pulse masks that direction's requests in the same cycle and drops any pending timeout.

Top module: `fifo_trig_req`

## Requirements
- R1: Fine mode for RX is aux_ctrl bit 7 and for TX is aux_ctrl bit 6. In fine mode the RX trigger is {trig_lvl[7:4], fifo_ctrl[7:6]} and the TX trigger is {trig_lvl[3:0], fifo_ctrl[5:4]}. A trigger value of 0 is treated as 1.
- R2: In coarse mode a nonzero 4-bit field gives a trigger of four times that field. A zero field selects from a table indexed by the 2-bit field: RX uses 8, 16, 56, 60 and TX uses 8, 16, 32, 56.
- R3: rx_data_irq is high exactly when rx_level is at least the RX trigger.
- R4: When aux_ctrl bit 3 is 0, tx_room_irq is high exactly when the free space (64 - tx_level) is at least the TX trigger. tx_dma_req follows the same comparison whenever TX requests are enabled.
- R5: When aux_ctrl bit 3 is 1, tx_room_irq is high only when tx_level is 0.
- R6: The DMA mode is aux_ctrl[2:1] when aux_ctrl bit 0 is 1, and {0, fifo_ctrl[3]} otherwise. The modes are 0 = off, 1 = both directions, 2 = RX only, 3 = TX only. rx_dma_req equals the RX comparison when RX requests are enabled and is 0 otherwise.
- R7: While 0 < rx_level < RX trigger, rx_to_irq rises after 4 character times (40 bit_tick pulses at the default 10 ticks per character) with no rx_push or rx_pop. Each rx_push or rx_pop restarts the count.
- R8: No timeout is raised when rx_level is 0 or has reached the trigger at expiry. A pending timeout is cleared by rx_pop.
- R9: rx_clr forces rx_data_irq, rx_to_irq and rx_dma_req low in the same cycle and clears the pending timeout. tx_clr forces tx_room_irq and tx_dma_req low in the same cycle.
- R10: After reset no timeout is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_ctrl | input | 8 | FIFO control byte: trigger low bits, DMA select bit 3 |
| trig_lvl | input | 8 | Trigger-level byte: RX nibble 7:4, TX nibble 3:0 |
| aux_ctrl | input | 8 | Fine-mode enables, TX-empty option, DMA mode override |
| rx_level | input | 7 | Bytes held in RX FIFO |
| tx_level | input | 7 | Bytes held in TX FIFO |
| rx_push | input | 1 | Byte written into RX FIFO |
| rx_pop | input | 1 | Byte read from RX FIFO |
| bit_tick | input | 1 | One pulse per serial bit time |
| rx_clr | input | 1 | RX FIFO clear pulse |
| tx_clr | input | 1 | TX FIFO clear pulse |
| rx_data_irq | output | 1 | RX trigger reached |
| rx_to_irq | output | 1 | RX idle timeout pending |
| tx_room_irq | output | 1 | TX room or empty interrupt |
| rx_dma_req | output | 1 | RX DMA request |
| tx_dma_req | output | 1 | TX DMA request |

## Verification
The table of vectors covers each way the trigger can be formed: coarse table entries, the coarse nibble scaled by four, fine values, and a fine value of zero. In each case the level sits one below the threshold and then exactly at it, so an off-by-one compare or a swapped field shows up. The DMA vectors set the override bit against the legacy select bit and step through all four modes, which separates the RX-only and TX-only gating. Directed timeout runs observe the tick just before and the tick at expiry, a restart midway through, levels of zero and at the trigger, and clears landing on a pending timeout.

// File: rtl/uft_pkg.sv
package uft_pkg;
   localparam int TRIG_W = 6;

   typedef enum logic [1:0] {
      DMA_OFF  = 2'd0,
      DMA_BOTH = 2'd1,
      DMA_RX   = 2'd2,
      DMA_TX   = 2'd3
   } dma_mode_e;

   function automatic dma_mode_e pick_mode(input logic [7:0] aux, input logic [7:0] fctl);
      if (aux[0]) return dma_mode_e'(aux[2:1]);
      return dma_mode_e'({1'b0, fctl[3]});
   endfunction
endpackage

// File: rtl/trig_decode.sv
module trig_decode
   import uft_pkg::*;
#(
   parameter bit IS_RX = 1'b1
) (
   input  logic              fine,
   input  logic [1:0]        lo_bits,
   input  logic [3:0]        nibble,
   output logic [TRIG_W-1:0] trig
);
   logic [TRIG_W-1:0] table_val;

   generate
      if (IS_RX) begin : g_rx_tab
         always_comb begin
            case (lo_bits)
               2'd0:    table_val = 6'd8;
               2'd1:    table_val = 6'd16;
               2'd2:    table_val = 6'd56;
               default: table_val = 6'd60;
            endcase
         end
      end else begin : g_tx_tab
         always_comb begin
            case (lo_bits)
               2'd0:    table_val = 6'd8;
               2'd1:    table_val = 6'd16;
               2'd2:    table_val = 6'd32;
               default: table_val = 6'd56;
            endcase
         end
      end
   endgenerate

   always_comb begin
      if (fine) begin
         trig = {nibble, lo_bits};
         if (trig == '0) trig = 6'd1;
      end else if (nibble != 4'd0) begin
         trig = {nibble, 2'b00};
      end else begin
         trig = table_val;
      end
   end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
   parameter int LVL_W   = 7,
   parameter int TRIG_W  = 6,
   parameter int TO_TICKS = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              clear,
   input  logic [LVL_W-1:0]  level,
   input  logic [TRIG_W-1:0] trig,
   output logic              pending
);
   localparam int CNT_W = $clog2(TO_TICKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_TICKS - 1);

   logic [CNT_W-1:0] cnt;
   logic             below;

   assign below = (level != '0) && (level < LVL_W'(trig));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         pending <= 1'b0;
      end else if (clear || level == '0) begin
         cnt     <= '0;
         pending <= 1'b0;
      end else begin
         if (rx_pop) pending <= 1'b0;
         if (rx_push || rx_pop) begin
            cnt <= '0;
         end else if (bit_tick) begin
            if (cnt == LAST) begin
               cnt <= '0;
               if (below) pending <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R8: a pop always leaves no timeout pending afterwards
   a_r8_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |=> !pending);
   // R7: timeout only appears on a bit tick
   a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(bit_tick));
endmodule

// File: rtl/fifo_trig_req.sv
module fifo_trig_req
   import uft_pkg::*;
#(
   parameter int DEPTH         = 64,
   parameter int CHAR_TICKS    = 10,
   parameter int TIMEOUT_CHARS = 4,
   parameter int LVL_W         = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       fifo_ctrl,
   input  logic [7:0]       trig_lvl,
   input  logic [7:0]       aux_ctrl,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             rx_push,
   input  logic             rx_pop,
   input  logic             bit_tick,
   input  logic             rx_clr,
   input  logic             tx_clr,
   output logic             rx_data_irq,
   output logic             rx_to_irq,
   output logic             tx_room_irq,
   output logic             rx_dma_req,
   output logic             tx_dma_req
);
   localparam int TO_TICKS = CHAR_TICKS * TIMEOUT_CHARS;

   generate
      if (DEPTH < 64 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 64");
      end
      if (TO_TICKS < 2) begin : g_bad_to
         $error("timeout window too short");
      end
   endgenerate

   logic [TRIG_W-1:0] rx_trig, tx_trig;
   logic [LVL_W-1:0]  tx_free;
   logic              rx_hit, tx_hit, to_pend;
   logic              rx_en, tx_en;
   dma_mode_e         mode;

   trig_decode #(.IS_RX(1'b1)) u_rx_dec (
      .fine(aux_ctrl[7]), .lo_bits(fifo_ctrl[7:6]), .nibble(trig_lvl[7:4]), .trig(rx_trig));
   trig_decode #(.IS_RX(1'b0)) u_tx_dec (
      .fine(aux_ctrl[6]), .lo_bits(fifo_ctrl[5:4]), .nibble(trig_lvl[3:0]), .trig(tx_trig));

   rx_idle_timer #(.LVL_W(LVL_W), .TRIG_W(TRIG_W), .TO_TICKS(TO_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_push(rx_push), .rx_pop(rx_pop),
      .clear(rx_clr), .level(rx_level), .trig(rx_trig), .pending(to_pend));

   always_comb begin
      tx_free = LVL_W'(DEPTH) - tx_level;
      rx_hit  = rx_level >= LVL_W'(rx_trig);
      tx_hit  = tx_free >= LVL_W'(tx_trig);
      mode    = pick_mode(aux_ctrl, fifo_ctrl);
      rx_en   = (mode == DMA_BOTH) || (mode == DMA_RX);
      tx_en   = (mode == DMA_BOTH) || (mode == DMA_TX);
   end

   assign rx_data_irq = rx_hit && !rx_clr;
   assign rx_dma_req  = rx_hit && rx_en && !rx_clr;
   assign rx_to_irq   = to_pend && !rx_clr;
   assign tx_room_irq = (aux_ctrl[3] ? (tx_level == '0) : tx_hit) && !tx_clr;
   assign tx_dma_req  = tx_hit && tx_en && !tx_clr;

   // R1: the decoded triggers are never zero
   a_r1_trig_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      rx_trig != '0 && tx_trig != '0);
   // R3: the RX request never runs ahead of the RX data interrupt
   a_r3_dma_within_irq: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> rx_data_irq);
   // R5: in empty mode the TX interrupt implies a drained FIFO
   a_r5_empty_only: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_ctrl[3] && tx_room_irq) |-> tx_level == '0);
   // R6: TX-only override never raises an RX request
   a_r6_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_ctrl[0] && aux_ctrl[2:1] == 2'b11) |-> !rx_dma_req);
   // R9: a clear leaves the timeout idle on the following cycle
   a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clr |=> !to_pend);
   // R9: TX clear masks TX requests at once
   a_r9_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clr |-> !tx_room_irq && !tx_dma_req);
endmodule

// File: tb/sim_fifo_trig_req.sv
`timescale 1ns/1ps
module sim_fifo_trig_req;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] fifo_ctrl = '0, trig_lvl = '0, aux_ctrl = '0;
   logic [6:0] rx_level = '0, tx_level = '0;
   logic rx_push = 0, rx_pop = 0, bit_tick = 0, rx_clr = 0, tx_clr = 0;
   logic rx_data_irq, rx_to_irq, tx_room_irq, rx_dma_req, tx_dma_req;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fifo_trig_req u0 (
      .clk(clk), .rst_n(rst_n), .fifo_ctrl(fifo_ctrl), .trig_lvl(trig_lvl), .aux_ctrl(aux_ctrl),
      .rx_level(rx_level), .tx_level(tx_level), .rx_push(rx_push), .rx_pop(rx_pop),
      .bit_tick(bit_tick), .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_data_irq(rx_data_irq),
      .rx_to_irq(rx_to_irq), .tx_room_irq(tx_room_irq), .rx_dma_req(rx_dma_req),
      .tx_dma_req(tx_dma_req));

   // {fifo_ctrl, trig_lvl, aux_ctrl, rx_level, tx_level, expect{rx_irq,tx_irq,rx_dma,tx_dma}}
   localparam int NV = 19;
   localparam logic [41:0] VEC [NV] = '{
      {8'h00, 8'h00, 8'h00, 7'd8,  7'd40, 4'hC},  // R2 R3 R4 coarse table 8/8
      {8'h00, 8'h00, 8'h00, 7'd7,  7'd57, 4'h0},
      {8'hC0, 8'h00, 8'h00, 7'd59, 7'd0,  4'h4},  // R2 RX entry 60
      {8'hC8, 8'h00, 8'h00, 7'd60, 7'd0,  4'hF},  // R6 legacy select -> both
      {8'h30, 8'h50, 8'h00, 7'd20, 7'd8,  4'hC},  // R2 nibble*4 and TX entry 56
      {8'h30, 8'h50, 8'h00, 7'd19, 7'd9,  4'h0},
      {8'h40, 8'h30, 8'h80, 7'd13, 7'd57, 4'h8},  // R1 fine RX 13
      {8'h40, 8'h30, 8'h80, 7'd12, 7'd56, 4'h4},
      {8'h00, 8'h00, 8'hC0, 7'd0,  7'd64, 4'h0},  // R1 zero -> 1
      {8'h00, 8'h00, 8'hC0, 7'd1,  7'd63, 4'hC},
      {8'h00, 8'h00, 8'h08, 7'd0,  7'd1,  4'h0},  // R5 not empty
      {8'h00, 8'h00, 8'h08, 7'd0,  7'd0,  4'h4},  // R5 empty
      {8'h08, 8'h00, 8'h05, 7'd8,  7'd0,  4'hE},  // R6 RX only
      {8'h08, 8'h00, 8'h07, 7'd8,  7'd0,  4'hD},  // R6 TX only
      {8'h08, 8'h00, 8'h01, 7'd8,  7'd0,  4'hC},  // R6 override off
      {8'h00, 8'h00, 8'h03, 7'd8,  7'd0,  4'hF},  // R6 both
      {8'h30, 8'h0F, 8'h4B, 7'd0,  7'd0,  4'h5},  // R4 R5 fine TX 63
      {8'h30, 8'h0F, 8'h4B, 7'd0,  7'd1,  4'h1},
      {8'h30, 8'h0F, 8'h4B, 7'd0,  7'd2,  4'h0}
   };

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [3:0] outs();
      return {rx_data_irq, tx_room_irq, rx_dma_req, tx_dma_req};
   endfunction

   task automatic ticks(input int n);
      @(negedge clk);
      bit_tick = 1'b1;
      repeat (n) @(negedge clk);
      bit_tick = 1'b0;
      #0.5;
   endtask

   task automatic pulse_push();
      @(negedge clk); rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset timeout", {3'b0, rx_to_irq}, 4'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {fifo_ctrl, trig_lvl, aux_ctrl, rx_level, tx_level} = VEC[i][41:4];
         #1;
         chk($sformatf("R3/R4 vector %0d", i), outs(), VEC[i][3:0]);
      end

      // R7: timeout expiry at exactly 40 ticks
      @(negedge clk);
      fifo_ctrl = 8'h00; trig_lvl = 8'h00; aux_ctrl = 8'h00; rx_level = 7'd3; tx_level = 7'd0;
      pulse_push();
      ticks(39);
      chk("R7 before expiry", {3'b0, rx_to_irq}, 4'h0);
      ticks(1);
      chk("R7 at expiry", {3'b0, rx_to_irq}, 4'h1);
      // R8: pop clears
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0; #0.5;
      chk("R8 pop clears", {3'b0, rx_to_irq}, 4'h0);
      // R7: restart on pop midway
      pulse_push();
      ticks(30);
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
      ticks(30);
      chk("R7 restarted", {3'b0, rx_to_irq}, 4'h0);
      ticks(10);
      chk("R7 after restart", {3'b0, rx_to_irq}, 4'h1);
      // R9: clear masks at once and clears pending
      @(negedge clk); rx_clr = 1'b1; #0.5;
      chk("R9 rx_clr same cycle", {3'b0, rx_to_irq}, 4'h0);
      @(negedge clk); rx_clr = 1'b0; #0.5;
      chk("R9 rx_clr pending gone", {3'b0, rx_to_irq}, 4'h0);
      // R8: level at trigger gives no timeout
      @(negedge clk); rx_level = 7'd8;
      pulse_push();
      ticks(45);
      chk("R8 at trigger", {3'b0, rx_to_irq}, 4'h0);
      // R8: empty FIFO gives no timeout
      @(negedge clk); rx_level = 7'd0;
      ticks(45);
      chk("R8 empty", {3'b0, rx_to_irq}, 4'h0);
      // R9: clear masks data and dma lines
      @(negedge clk);
      aux_ctrl = 8'h03; rx_level = 7'd10; tx_level = 7'd0; rx_clr = 1'b1; tx_clr = 1'b1; #1;
      chk("R9 both clears", outs(), 4'h0);
      @(negedge clk); rx_clr = 1'b0; #1;
      chk("R9 tx_clr only", outs(), 4'hA);
      @(negedge clk); tx_clr = 1'b0; #1;
      chk("R9 released", outs(), 4'hF);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule